// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block places a small dual-port RAM between two processors and adds one interrupt line per side for message passing. The two topmost words of the RAM act as mailboxes. The last word belongs to the right port and the word just below it belongs to the left port. When one side writes a message into the other side's mailbox, the owner's interrupt goes active. The owner clears its interrupt by reading its own mailbox. The interrupt logic only watches addresses and access types. It never looks at the message contents, which are free user data held in the RAM.

Each port also receives a busy input from an external contention arbiter. While a port's busy is high, its accesses can neither raise the opposite interrupt nor clear its own. The memory access itself still takes place. All ports are synchronous to one clock. Interrupt outputs are active low.

Top module: `mbox_irq_dpram`

## Requirements
- R1: During and directly after reset, `lp_irq_n`, `rp_irq_n`, `lp_rdata` and `rp_rdata` are 1, 1, 0 and 0.
- R2: The right mailbox is at address 2**ADDR_W-1 and the left mailbox is at address 2**ADDR_W-2. With the defaults these are 63 and 62.
- R3: A left write (`lp_en`=1, `lp_we`=1) to the right mailbox while `lp_busy`=0 drives `rp_irq_n` low from the clock edge that takes the write.
- R4: A right write to the left mailbox while `rp_busy`=0 drives `lp_irq_n` low from the clock edge that takes the write.
- R5: An owner read (`en`=1, `we`=0, `oe`=1) of its own mailbox while its busy is 0 drives its interrupt high from that clock edge.
- R6: Reading the other port's mailbox, or writing one's own mailbox, leaves both interrupts unchanged.
- R7: While a port's busy is 1, its write to the other mailbox does not set the other interrupt.
- R8: While a port's busy is 1, its read of its own mailbox does not clear its own interrupt.
- R9: If a flag's set and clear conditions occur in the same cycle, the flag ends up set (interrupt low).
- R10: A write is stored at the clock edge. A read returns the word on `rdata` one edge later, with read-before-write order against a write in the same cycle. Mailbox contents are stored like any other data, whatever the busy inputs are.
- R11: If both ports write the same address in one cycle, the left port's data is kept.
- R12: An access with `en`=1, `we`=0, `oe`=0 is not a read. It leaves `rdata` unchanged and clears no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp_en | input | 1 | Left port access enable |
| lp_we | input | 1 | Left port write (1) or read (0) |
| lp_oe | input | 1 | Left port output enable, needed for a read |
| lp_busy | input | 1 | Left port lost contention |
| lp_addr | input | ADDR_W | Left port word address |
| lp_wdata | input | DATA_W | Left port write data |
| lp_rdata | output | DATA_W | Left port registered read data |
| lp_irq_n | output | 1 | Left port interrupt, active low |
| rp_en | input | 1 | Right port access enable |
| rp_we | input | 1 | Right port write (1) or read (0) |
| rp_oe | input | 1 | Right port output enable, needed for a read |
| rp_busy | input | 1 | Right port lost contention |
| rp_addr | input | ADDR_W | Right port word address |
| rp_wdata | input | DATA_W | Right port write data |
| rp_rdata | output | DATA_W | Right port registered read data |
| rp_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The assertions assume that every input is a known value at each clock edge after reset. They also assume that a busy input applies to the access presented in the same cycle. The bench drives all inputs at the falling edge, so nothing changes near the sampling edge. Before any read, it writes every word of the RAM, so reads never return undefined contents. In the random phase, busy is driven independently of address, and addresses are weighted toward the two mailbox words. This lets busy-masked events and simultaneous set and clear occur often.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  function automatic int right_mbox(input int aw);
    return (1 << aw) - 1;
  endfunction

  function automatic int left_mbox(input int aw);
    return (1 << aw) - 2;
  endfunction

  function automatic logic is_read(input logic en, input logic we, input logic oe);
    return en & ~we & oe;
  endfunction

  function automatic logic is_write(input logic en, input logic we);
    return en & we;
  endfunction

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
  parameter int ADDR_W = 6,
  parameter int OWN_BOX = 62,
  parameter int PEER_BOX = 63
) (
  input  logic              en,
  input  logic              we,
  input  logic              oe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_fire,
  output logic              wr_fire,
  output logic              set_peer,
  output logic              clr_own
);
  localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
  localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

  always_comb begin
    rd_fire  = mbox_pkg::is_read(en, we, oe);
    wr_fire  = mbox_pkg::is_write(en, we);
    set_peer = wr_fire && (addr == PEER_A) && !busy;
    clr_own  = rd_fire && (addr == OWN_A) && !busy;
  end
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pending <= 1'b0;
    else if (set_i) pending <= 1'b1;
    else if (clr_i) pending <= 1'b0;
  end

  assign irq_n_o = ~pending;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !irq_n_o); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> irq_n_o); // R5
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(irq_n_o)); // R6
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // right first, left last: left wins a same-address collision
  always_ff @(posedge clk) begin
    if (r_wr) mem[r_addr] <= r_wdata;
    if (l_wr) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_rd) l_rdata <= mem[l_addr];
      if (r_rd) r_rdata <= mem[r_addr];
    end
  end

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> $stable(l_rdata)); // R12
endmodule

// File: rtl/mbox_irq_dpram.sv
module mbox_irq_dpram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_en,
  input  logic              lp_we,
  input  logic              lp_oe,
  input  logic              lp_busy,
  input  logic [ADDR_W-1:0] lp_addr,
  input  logic [DATA_W-1:0] lp_wdata,
  output logic [DATA_W-1:0] lp_rdata,
  output logic              lp_irq_n,
  input  logic              rp_en,
  input  logic              rp_we,
  input  logic              rp_oe,
  input  logic              rp_busy,
  input  logic [ADDR_W-1:0] rp_addr,
  input  logic [DATA_W-1:0] rp_wdata,
  output logic [DATA_W-1:0] rp_rdata,
  output logic              rp_irq_n
);
  localparam int BOX_R = mbox_pkg::right_mbox(ADDR_W);
  localparam int BOX_L = mbox_pkg::left_mbox(ADDR_W);
  localparam logic [ADDR_W-1:0] BOX_R_A = ADDR_W'(BOX_R);
  localparam logic [ADDR_W-1:0] BOX_L_A = ADDR_W'(BOX_L);

  logic l_rd, l_wr, l_set_r, l_clr_l;
  logic r_rd, r_wr, r_set_l, r_clr_r;

  mbox_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(BOX_L), .PEER_BOX(BOX_R)) u_dec_l (
    .en(lp_en), .we(lp_we), .oe(lp_oe), .busy(lp_busy), .addr(lp_addr),
    .rd_fire(l_rd), .wr_fire(l_wr), .set_peer(l_set_r), .clr_own(l_clr_l));

  mbox_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(BOX_R), .PEER_BOX(BOX_L)) u_dec_r (
    .en(rp_en), .we(rp_we), .oe(rp_oe), .busy(rp_busy), .addr(rp_addr),
    .rd_fire(r_rd), .wr_fire(r_wr), .set_peer(r_set_l), .clr_own(r_clr_r));

  mbox_irq_flag u_flag_l (.clk(clk), .rst_n(rst_n), .set_i(r_set_l), .clr_i(l_clr_l), .irq_n_o(lp_irq_n));
  mbox_irq_flag u_flag_r (.clk(clk), .rst_n(rst_n), .set_i(l_set_r), .clr_i(r_clr_r), .irq_n_o(rp_irq_n));

  mbox_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(lp_addr), .l_wdata(lp_wdata), .l_rdata(lp_rdata),
    .r_wr(r_wr), .r_rd(r_rd), .r_addr(rp_addr), .r_wdata(rp_wdata), .r_rdata(rp_rdata));

  AST_RIRQ_ONLY_BY_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_irq_n && !(lp_en && lp_we && lp_addr == BOX_R_A && !lp_busy)) |=> rp_irq_n); // R7
  AST_LIRQ_ONLY_BY_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_irq_n && !(rp_en && rp_we && rp_addr == BOX_L_A && !rp_busy)) |=> lp_irq_n); // R7
  AST_RIRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rp_irq_n && !(rp_en && !rp_we && rp_oe && rp_addr == BOX_R_A && !rp_busy)) |=> !rp_irq_n); // R8
  AST_LIRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_irq_n && !(lp_en && !lp_we && lp_oe && lp_addr == BOX_L_A && !lp_busy)) |=> !lp_irq_n); // R8
endmodule

// File: tb/sim_mbox_irq_dpram.sv
`timescale 1ns/1ps
module sim_mbox_irq_dpram;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int TOP_R = 63;
  localparam int TOP_L = 62;

  logic clk = 0;
  logic rst_n = 0;
  logic lp_en = 0, lp_we = 0, lp_oe = 0, lp_busy = 0;
  logic rp_en = 0, rp_we = 0, rp_oe = 0, rp_busy = 0;
  logic [AW-1:0] lp_addr = '0, rp_addr = '0;
  logic [DW-1:0] lp_wdata = '0, rp_wdata = '0;
  logic [DW-1:0] lp_rdata, rp_rdata;
  logic lp_irq_n, rp_irq_n;

  always #2.5 clk = ~clk;

  mbox_irq_dpram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lp_en(lp_en), .lp_we(lp_we), .lp_oe(lp_oe), .lp_busy(lp_busy), .lp_addr(lp_addr),
    .lp_wdata(lp_wdata), .lp_rdata(lp_rdata), .lp_irq_n(lp_irq_n),
    .rp_en(rp_en), .rp_we(rp_we), .rp_oe(rp_oe), .rp_busy(rp_busy), .rp_addr(rp_addr),
    .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .rp_irq_n(rp_irq_n));

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int ref_mem [64];
  bit ref_lflag = 0, ref_rflag = 0;
  int ref_lrd = 0, ref_rrd = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(lp_irq_n === !ref_lflag, "lp_irq_n", int'(lp_irq_n), int'(!ref_lflag));
    chk(rp_irq_n === !ref_rflag, "rp_irq_n", int'(rp_irq_n), int'(!ref_rflag));
    chk(lp_rdata === DW'(ref_lrd), "lp_rdata", int'(lp_rdata), ref_lrd);
    chk(rp_rdata === DW'(ref_rrd), "rp_rdata", int'(rp_rdata), ref_rrd);
  endtask

  // behavioural model: one clock edge worth of effect
  task automatic step();
    bit lr, rr, lw, rw, set_l, set_r, clr_l, clr_r;
    @(posedge clk);
    lr = lp_en && !lp_we && lp_oe;
    rr = rp_en && !rp_we && rp_oe;
    lw = lp_en && lp_we;
    rw = rp_en && rp_we;
    if (lr) ref_lrd = ref_mem[lp_addr];
    if (rr) ref_rrd = ref_mem[rp_addr];
    set_r = lw && int'(lp_addr) == TOP_R && !lp_busy;
    set_l = rw && int'(rp_addr) == TOP_L && !rp_busy;
    clr_l = lr && int'(lp_addr) == TOP_L && !lp_busy;
    clr_r = rr && int'(rp_addr) == TOP_R && !rp_busy;
    if (rw) ref_mem[rp_addr] = int'(rp_wdata);
    if (lw) ref_mem[lp_addr] = int'(lp_wdata);
    ref_rflag = set_r ? 1'b1 : (clr_r ? 1'b0 : ref_rflag);
    ref_lflag = set_l ? 1'b1 : (clr_l ? 1'b0 : ref_lflag);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    lp_en = 0; lp_we = 0; lp_oe = 0; lp_busy = 0;
    rp_en = 0; rp_we = 0; rp_oe = 0; rp_busy = 0;
  endtask

  task automatic lwrite(input int a, input int d, input bit b);
    lp_en = 1; lp_we = 1; lp_oe = 0; lp_addr = AW'(a); lp_wdata = DW'(d); lp_busy = b;
  endtask
  task automatic rwrite(input int a, input int d, input bit b);
    rp_en = 1; rp_we = 1; rp_oe = 0; rp_addr = AW'(a); rp_wdata = DW'(d); rp_busy = b;
  endtask
  task automatic lread(input int a, input bit oe, input bit b);
    lp_en = 1; lp_we = 0; lp_oe = oe; lp_addr = AW'(a); lp_busy = b;
  endtask
  task automatic rread(input int a, input bit oe, input bit b);
    rp_en = 1; rp_we = 0; rp_oe = oe; rp_addr = AW'(a); rp_busy = b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare_all();
    rst_n = 1;
    step();

    // R10: fill memory; left writes own box 62, right writes own box 63 (R6)
    cur_req = "R10/R6";
    for (int a = 0; a < 32; a++) begin
      lwrite(2*a, 16'h1000 + 2*a, 0);
      rwrite(2*a + 1, 16'h2000 + 2*a + 1, 0);
      step();
    end
    idle(); step();
    chk(lp_irq_n === 1'b1 && rp_irq_n === 1'b1, "R6 own-box writes", int'({lp_irq_n, rp_irq_n}), 3);

    cur_req = "R2/R3";
    lwrite(TOP_R, 16'hBEEF, 0); step(); idle();
    chk(rp_irq_n === 1'b0, "R3 right irq set", int'(rp_irq_n), 0);
    cur_req = "R6";
    lread(TOP_R, 1, 0); step(); idle();
    chk(rp_irq_n === 1'b0 && lp_rdata === 16'hBEEF, "R6 peer read", int'(lp_rdata), 16'hBEEF);
    cur_req = "R12";
    rread(TOP_R, 0, 0); step(); idle();
    chk(rp_irq_n === 1'b0, "R12 no-oe read", int'(rp_irq_n), 0);
    cur_req = "R8";
    rread(TOP_R, 1, 1); step(); idle();
    chk(rp_irq_n === 1'b0, "R8 busy read", int'(rp_irq_n), 0);
    cur_req = "R5";
    rread(TOP_R, 1, 0); step(); idle();
    chk(rp_irq_n === 1'b1 && rp_rdata === 16'hBEEF, "R5 right clear", int'(rp_irq_n), 1);

    cur_req = "R2/R4";
    rwrite(TOP_L, 16'h5A5A, 0); step(); idle();
    chk(lp_irq_n === 1'b0, "R4 left irq set", int'(lp_irq_n), 0);
    cur_req = "R5";
    lread(TOP_L, 1, 0); step(); idle();
    chk(lp_irq_n === 1'b1 && lp_rdata === 16'h5A5A, "R5 left clear", int'(lp_rdata), 16'h5A5A);

    cur_req = "R7";
    lwrite(TOP_R, 16'h7777, 1); step(); idle();
    chk(rp_irq_n === 1'b1, "R7 busy write", int'(rp_irq_n), 1);
    rread(TOP_R, 1, 0); step(); idle();
    chk(rp_rdata === 16'h7777, "R10 busy write stored", int'(rp_rdata), 16'h7777);

    cur_req = "R9";
    lwrite(TOP_R, 16'h0101, 0); step(); idle();
    lwrite(TOP_R, 16'h0202, 0); rread(TOP_R, 1, 0); step(); idle();
    chk(rp_irq_n === 1'b0 && rp_rdata === 16'h0101, "R9 set wins", int'(rp_irq_n), 0);
    rread(TOP_R, 1, 0); step(); idle();

    cur_req = "R11";
    lwrite(10, 16'hAAAA, 0); rwrite(10, 16'hBBBB, 0); step(); idle();
    rread(10, 1, 0); step(); idle();
    chk(rp_rdata === 16'hAAAA, "R11 left wins", int'(rp_rdata), 16'hAAAA);

    cur_req = "R10";
    lwrite(20, 16'hC0DE, 0); rread(20, 1, 0); step(); idle();
    chk(rp_rdata === 16'h1014, "R10 read-before-write", int'(rp_rdata), 16'h1014);

    cur_req = "R3/R4/R5/R7/R8/R9";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      lp_en = 1'($urandom); lp_we = 1'($urandom); lp_oe = 1'($urandom);
      rp_en = 1'($urandom); rp_we = 1'($urandom); rp_oe = 1'($urandom);
      lp_busy = ($urandom % 4) == 0; rp_busy = ($urandom % 4) == 0;
      sel = $urandom % 4;
      lp_addr = (sel < 2) ? AW'(62 + sel) : AW'($urandom);
      sel = $urandom % 4;
      rp_addr = (sel < 2) ? AW'(62 + sel) : AW'($urandom);
      lp_wdata = DW'($urandom); rp_wdata = DW'($urandom);
      step();
    end
    idle(); step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule